// File: doc/BRIEF.md
# Fractional-Correction Baud Clock Timer

This block is an 8-bit down-counting reload timer that produces a serial bit clock and an underflow pulse. A prescaler outside the block supplies a one-cycle count enable. The block sees one count step each time that enable is high. The counter starts from a programmable reload value. Each time it passes zero it underflows, reloads, and toggles the output clock. The output clock therefore runs at 50% duty, with a half-period of `reload + 1` count steps.

Integer reload values alone often cannot hit a baud rate exactly. A 4-bit correction setting trims the average period in steps of one sixteenth of a count step. Underflow intervals are numbered 1 to 16 in a repeating frame. The setting picks that many intervals, and each picked interval is stretched by one extra count step. The intervals are spread evenly over the frame by a bit-reversed ranking, so each larger setting adds one interval to the set used by the setting below it. The underflow pulse moves with the stretched edge.

Top module: `fine_baud_timer`

## Requirements
- R1: After reset, and with `run` low, `baud_clk` and `uf_pulse` are 0.
- R2: With `fine_sel` = 0, every underflow interval lasts exactly `reload_val + 1` count enables. This holds for the first interval after `run` rises as well, and includes `reload_val` = 0, which gives one enable per interval.
- R3: `uf_pulse` is high for the single clock cycle after the clock edge at which the final count enable of an interval was sampled. With sparse enables, it is low again in the next cycle.
- R4: `baud_clk` toggles exactly at each underflow, so that it reads 1 after odd-numbered underflows and 0 after even-numbered ones, counted from the start.
- R5: In every 16-interval frame, exactly `fine_sel` intervals are stretched, each by exactly one count enable. Interval 1 of a frame is never stretched.
- R6: Interval k (1..16) is stretched when rank(k) < `fine_sel`. Here rank(k) is the 4-bit bit-reversal of (16 − k) mod 16. As a result, setting 1 stretches interval 16 only, setting 8 stretches all even intervals, and setting 15 stretches intervals 2 to 16.
- R7: A change to `fine_sel` while running has no effect until the current 16-interval frame has completed. The next frame then follows the new setting.
- R8: While `run` is low, no underflow pulse occurs and `baud_clk` is 0. When `run` rises again, interval numbering restarts at 1.
- R9: While `cnt_en` is low the counter does not move: no underflow occurs, `baud_clk` holds, and the interval length counted in enables is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-step enable from the prescaler |
| run | input | 1 | 1 = timer running, 0 = stopped and reloaded |
| reload_val | input | 8 | Reload value; half-period is reload_val+1 steps |
| fine_sel | input | 4 | Number of stretched intervals per 16-interval frame |
| baud_clk | output | 1 | Serial clock, toggles on each underflow |
| uf_pulse | output | 1 | One-cycle pulse per underflow |

## Verification
A wrong counter value or a lost hold flag shows up at the very next underflow. That interval comes out one or more count enables longer or shorter than `reload_val + 1`, and the edge of `baud_clk` moves with it. A wrong interval index or a wrong latched setting is quieter: it only moves which intervals within the frame are stretched. It can therefore take up to 16 underflows to appear, or up to two frames when a mid-frame setting change is involved. For that reason, every pattern is measured interval by interval over whole frames.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  // Reverse the low `w` bits of v.
  function automatic int rev_bits(input int v, input int w);
    int r;
    r = 0;
    for (int i = 0; i < w; i++) begin
      r = (r << 1) | ((v >> i) & 1);
    end
    return r;
  endfunction

  // Slot s (0-based; interval s+1) is stretched when the bit-reversed
  // complement of its index ranks below the correction setting.
  function automatic logic slot_marked(input int slot, input int fine, input int w);
    int mask;
    mask = (1 << w) - 1;
    return rev_bits((~slot) & mask, w) < fine;
  endfunction

endpackage

// File: rtl/fbt_down_counter.sv
module fbt_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             stretch_req,
  output logic [CNT_W-1:0] cnt_val,
  output logic             uf_evt
);

  logic at_zero;
  logic held;
  logic hold_now;

  assign at_zero  = (cnt_val == '0);
  assign hold_now = stretch_req && !held;
  assign uf_evt   = run && cnt_en && at_zero && !hold_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val <= '0;
      held    <= 1'b0;
    end else if (!run) begin
      cnt_val <= reload_val;
      held    <= 1'b0;
    end else if (cnt_en) begin
      if (!at_zero) begin
        cnt_val <= cnt_val - 1'b1;
      end else if (hold_now) begin
        held <= 1'b1;
      end else begin
        cnt_val <= reload_val;
        held    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fbt_slot_seq.sv
module fbt_slot_seq
  import fbt_pkg::*;
#(
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              uf_evt,
  input  logic [FINE_W-1:0] fine_sel,
  output logic [FINE_W-1:0] slot_idx,
  output logic [FINE_W-1:0] fine_act,
  output logic              stretch_req,
  output logic              frame_end
);

  localparam logic [FINE_W-1:0] LAST_SLOT = '1;

  assign frame_end   = uf_evt && (slot_idx == LAST_SLOT);
  assign stretch_req = slot_marked(int'(slot_idx), int'(fine_act), FINE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx <= '0;
      fine_act <= '0;
    end else if (!run) begin
      slot_idx <= '0;
      fine_act <= fine_sel;
    end else if (uf_evt) begin
      slot_idx <= slot_idx + 1'b1;
      if (frame_end) begin
        fine_act <= fine_sel;
      end
    end
  end

endmodule

// File: rtl/fbt_clk_out.sv
module fbt_clk_out (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic uf_evt,
  output logic baud_clk,
  output logic uf_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_clk <= 1'b0;
      uf_pulse <= 1'b0;
    end else begin
      uf_pulse <= uf_evt;
      if (!run) begin
        baud_clk <= 1'b0;
      end else if (uf_evt) begin
        baud_clk <= !baud_clk;
      end
    end
  end

endmodule

// File: rtl/fine_baud_timer.sv
module fine_baud_timer #(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              run,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic [FINE_W-1:0] fine_sel,
  output logic              baud_clk,
  output logic              uf_pulse
);

  logic [CNT_W-1:0]  cnt_val;
  logic [FINE_W-1:0] slot_idx;
  logic [FINE_W-1:0] fine_act;
  logic              stretch_req;
  logic              frame_end;
  logic              uf_evt;

  fbt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cnt_en      (cnt_en),
    .reload_val  (reload_val),
    .stretch_req (stretch_req),
    .cnt_val     (cnt_val),
    .uf_evt      (uf_evt)
  );

  fbt_slot_seq #(.FINE_W(FINE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .uf_evt      (uf_evt),
    .fine_sel    (fine_sel),
    .slot_idx    (slot_idx),
    .fine_act    (fine_act),
    .stretch_req (stretch_req),
    .frame_end   (frame_end)
  );

  fbt_clk_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .uf_evt   (uf_evt),
    .baud_clk (baud_clk),
    .uf_pulse (uf_pulse)
  );

endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
  parameter int CNT_W  = 8,
  parameter int FINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              cnt_en,
  input logic              uf_evt,
  input logic              uf_pulse,
  input logic              baud_clk,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [FINE_W-1:0] slot_idx,
  input logic [FINE_W-1:0] fine_act,
  input logic              stretch_req,
  input logic              frame_end
);

  // R3
  pulse_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_pulse);

  // R3
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse |-> $past(cnt_en));

  // R4
  baud_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ((baud_clk != $past(baud_clk)) == uf_pulse));

  // R5
  first_slot_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == '0) |-> !stretch_req);

  // R7
  fine_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> $stable(fine_act));

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!uf_pulse && !baud_clk));

  // R8
  stopped_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (slot_idx == '0));

  // R9
  no_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_en) |=> ($stable(cnt_val) && !uf_pulse));

endmodule

bind fine_baud_timer fbt_checker #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .cnt_en      (cnt_en),
  .uf_evt      (uf_evt),
  .uf_pulse    (uf_pulse),
  .baud_clk    (baud_clk),
  .cnt_val     (cnt_val),
  .slot_idx    (slot_idx),
  .fine_act    (fine_act),
  .stretch_req (stretch_req),
  .frame_end   (frame_end)
);

// File: tb/fine_baud_timer_test.sv
`timescale 1ns/1ps
module fine_baud_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       run = 1'b0;
  logic [7:0] reload_val = 8'd0;
  logic [3:0] fine_sel = 4'd0;
  logic       baud_clk;
  logic       uf_pulse;

  int checks = 0;
  int fails = 0;
  int ecount = 0;
  int cyc = 0;
  int phase = 0;
  bit en_on = 1'b1;
  bit gap_mode = 1'b0;
  bit done = 1'b0;

  fine_baud_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run),
    .reload_val(reload_val), .fine_sel(fine_sel),
    .baud_clk(baud_clk), .uf_pulse(uf_pulse)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (cnt_en) ecount++;
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    phase++;
    cnt_en <= gap_mode ? ((phase % 3) == 0) : en_on;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int brev4(input int r);
    return ((r & 1) << 3) | ((r & 2) << 1) | ((r & 4) >> 1) | ((r & 8) >> 3);
  endfunction

  // Interval k (1..16) stretched if it is among the first `f` in rank order.
  function automatic int exp_extra(input int f, input int k);
    for (int r = 0; r < f; r++) begin
      int p;
      p = brev4(r);
      if (((p == 0) ? 16 : 16 - p) == k) return 1;
    end
    return 0;
  endfunction

  task automatic next_interval(output int n);
    n = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (uf_pulse) begin
        n = ecount;
        ecount = 0;
        return;
      end
    end
  endtask

  task automatic start_timer();
    @(negedge clk);
    run = 1'b1;
    ecount = 0;
  endtask

  task automatic stop_timer();
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(baud_clk == 1'b0, "R1 baud_clk after reset", baud_clk, 0);
    chk(uf_pulse == 1'b0, "R1 uf_pulse after reset", uf_pulse, 0);
  endtask

  // Run two frames and check every interval length and baud level.
  task automatic t_pattern(input int f, input int rl, input bit gap);
    int n;
    int total;
    gap_mode = gap;
    fine_sel = 4'(f);
    reload_val = 8'(rl);
    start_timer();
    for (int fr = 0; fr < 2; fr++) begin
      total = 0;
      for (int k = 1; k <= 16; k++) begin
        next_interval(n);
        total += n - (rl + 1);
        chk(n == rl + 1 + exp_extra(f, k),
            (f == 0) ? "R2 interval length" : "R6 interval pattern",
            n, rl + 1 + exp_extra(f, k));
        chk(baud_clk == 1'(k % 2), "R4 baud level", baud_clk, k % 2);
        if (k == 1) chk(n == rl + 1, "R5 interval 1 unstretched", n, rl + 1);
        if (gap) begin
          @(negedge clk);
          chk(uf_pulse == 1'b0, "R3 single-cycle pulse", uf_pulse, 0);
        end
      end
      chk(total == f, "R5 stretches per frame", total, f);
    end
    stop_timer();
    gap_mode = 1'b0;
  endtask

  task automatic t_fine_change();
    int n;
    fine_sel = 4'd0;
    reload_val = 8'd3;
    start_timer();
    for (int k = 1; k <= 5; k++) next_interval(n);
    fine_sel = 4'd15;
    for (int k = 6; k <= 16; k++) begin
      next_interval(n);
      chk(n == 4, "R7 old setting kept mid-frame", n, 4);
    end
    for (int k = 1; k <= 16; k++) begin
      next_interval(n);
      chk(n == 4 + exp_extra(15, k), "R7 new setting next frame", n, 4 + exp_extra(15, k));
    end
    stop_timer();
  endtask

  task automatic t_stop_restart();
    int n;
    bit seen;
    fine_sel = 4'd1;
    reload_val = 8'd2;
    start_timer();
    for (int k = 1; k <= 7; k++) next_interval(n);
    @(negedge clk);
    run = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 0 && (uf_pulse || baud_clk)) seen = 1'b1;
    end
    chk(!seen, "R8 quiet while stopped", seen, 0);
    chk(baud_clk == 1'b0, "R8 baud low while stopped", baud_clk, 0);
    start_timer();
    for (int k = 1; k <= 16; k++) begin
      next_interval(n);
      chk(n == 3 + exp_extra(1, k), "R8 numbering restarts", n, 3 + exp_extra(1, k));
    end
    stop_timer();
  endtask

  task automatic t_no_enable();
    int n;
    bit seen;
    fine_sel = 4'd0;
    reload_val = 8'd4;
    en_on = 1'b0;
    start_timer();
    repeat (3) @(negedge clk);
    seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (uf_pulse || baud_clk) seen = 1'b1;
    end
    chk(!seen, "R9 no activity without enable", seen, 0);
    en_on = 1'b1;
    next_interval(n);
    chk(n == 5, "R9 count held while disabled", n, 5);
    next_interval(n);
    chk(n == 5, "R9 following interval", n, 5);
    stop_timer();
  endtask

  initial begin
    t_reset();
    t_pattern(0, 5, 1'b0);
    t_pattern(0, 0, 1'b0);
    t_pattern(1, 3, 1'b0);
    t_pattern(8, 2, 1'b1);
    t_pattern(15, 4, 1'b0);
    t_pattern(3, 1, 1'b1);
    t_pattern(6, 7, 1'b0);
    t_fine_change();
    t_stop_restart();
    t_no_enable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule